// File: doc/BRIEF.md
# Flash Erase Status Poller

This block produces the status byte that a NOR-style flash device returns on its data bus while the program/erase controller is busy. It also decides, read by read, whether the status byte or the array data should drive the bus. Four flags make up the byte: a program-error flag, an erase-started flag, an alternating bit that flips as the host polls, and a buffered-program-abort flag. All unused bit positions read as 0.

The surrounding logic supplies the controller phase (block collection window, erasing, suspended, done), a per-block mask of blocks chosen for erase and a per-block mask of blocks that failed to erase. A host polling loop issues read strobes with a block index. Reads of blocks that are being erased, or that failed after an erroneous erase, make the alternating bit flip on the following cycle. Reads of other blocks leave it unchanged. Protected blocks are simply left out of the erase mask. The array storage and the command decoder are outside this block.

Top module: `flash_status_poll`

## Requirements
- R1: While reset is asserted and right after it, the status byte is 0x00, including the alternating bit, and `stat_sel` is 0 when no phase input is active.
- R2: A program event whose new data has a 1 where the old data has a 0 sets the error flag (bit 5) on the next cycle. A program event that only clears bits leaves it at 0. The flag stays set until a general reset command.
- R3: The erase-started flag (bit 3) is 0 while the block collection window is open, becomes 1 on the cycle after the erasing phase is seen, and stays 1 through suspend. The collection window, the done phase or a general reset clear it.
- R4: In the collection or erasing phase without an error, `stat_sel` is 1 for every block. During erasing, each read strobe to a block in `erase_sel` inverts the alternating bit (bit 2) for the next cycle. Reads of other blocks and idle cycles leave it unchanged.
- R5: During suspend without an error, reads of blocks in `erase_sel` give `stat_sel` 1 and invert bit 2. Reads of blocks outside `erase_sel` give `stat_sel` 0 and leave bit 2 unchanged.
- R6: While the error flag is set, `stat_sel` is 1 for every block. Bit 2 inverts only on reads of blocks in `erase_fail` and holds on reads of blocks that erased correctly.
- R7: A buffer-abort event sets bit 1 and forces `stat_sel` to 1. The flag survives a general reset and is cleared only by the abort-reset command, which wins over an abort in the same cycle.
- R8: With no phase active, no error and no abort (read mode), `stat_sel` is 0 for every block.
- R9: A general reset command clears the error flag, the erase-started flag and the alternating bit on the next cycle, and wins over any set in the same cycle.
- R10: After reset the alternating bit starts at 0, so the first qualifying read returns bit 2 = 0 and the next one returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_stb | input | 1 | Bus read strobe, one per read |
| rd_blk | input | $clog2(NUM_BLOCKS) | Block index of the read address |
| erase_sel | input | NUM_BLOCKS | Blocks chosen for the current erase (protected blocks excluded) |
| erase_fail | input | NUM_BLOCKS | Blocks that failed to erase |
| ph_collect | input | 1 | Controller still accepts extra blocks |
| ph_erase | input | 1 | Controller is erasing |
| ph_suspend | input | 1 | Erase is suspended |
| ph_done | input | 1 | Operation has completed |
| prog_stb | input | 1 | Program attempt event |
| prog_old | input | DATA_W | Stored data at the program address |
| prog_new | input | DATA_W | Data the program attempt writes |
| buf_abort | input | 1 | Buffered program operation aborted |
| cmd_reset | input | 1 | General reset command strobe |
| cmd_abort_reset | input | 1 | Abort-and-reset command strobe |
| stat_byte | output | 8 | Status byte: bit5 error, bit3 erase started, bit2 alternating, bit1 abort |
| stat_sel | output | 1 | 1 when the status byte, not array data, drives the bus |

## Verification
The vector table polls through a full erase. It reads selected and unselected blocks in the collection, erasing, suspended and done phases. Comparing bit 2 and `stat_sel` across these reads separates toggling on selected blocks from toggling on any read, and separates suspend pass-through from busy-for-all behaviour. Directed sequences then compare failed and healthy blocks after an error, and program data that clears bits against data that raises them. They also run the abort flag against both reset commands, including the same-cycle clear-versus-set cases, and check whether the erase-started flag is cleared when the collection window reopens.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  localparam int STAT_W    = 8;
  localparam int BIT_ERR   = 5;
  localparam int BIT_TIMER = 3;
  localparam int BIT_TOG   = 2;
  localparam int BIT_ABORT = 1;
endpackage

// File: rtl/fsp_flags.sv
module fsp_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_stb,
  input  logic [DATA_W-1:0] prog_old,
  input  logic [DATA_W-1:0] prog_new,
  input  logic              buf_abort,
  input  logic              cmd_reset,
  input  logic              cmd_abort_reset,
  input  logic              ph_collect,
  input  logic              ph_erase,
  input  logic              ph_done,
  output logic              err_q,
  output logic              timer_q,
  output logic              abort_q
);
  logic raise_attempt;
  logic err_d, timer_d, abort_d;

  // a program can only clear bits; any 0->1 request is an error
  assign raise_attempt = prog_stb && (|(~prog_old & prog_new));

  always_comb begin
    err_d = err_q | raise_attempt;
    if (cmd_reset) err_d = 1'b0;

    timer_d = timer_q;
    if (ph_erase)                  timer_d = 1'b1;
    else if (ph_collect || ph_done) timer_d = 1'b0;
    if (cmd_reset) timer_d = 1'b0;

    abort_d = abort_q | buf_abort;
    if (cmd_abort_reset) abort_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      timer_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      err_q   <= err_d;
      timer_q <= timer_d;
      abort_q <= abort_d;
    end
  end

  a_r2_err_on_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb && (|(~prog_old & prog_new)) && !cmd_reset) |=> err_q);
  a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !cmd_reset) |=> err_q);
  a_r3_timer_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_collect && !ph_erase) |=> !timer_q);
  a_r7_abort_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q && !cmd_abort_reset) |=> abort_q);
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (!err_q && !timer_q));
endmodule

// File: rtl/fsp_toggle.sv
module fsp_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic clr,
  output logic tog_q
);
  logic tog_d;
  logic tog_en;

  assign tog_en = advance || clr;

  always_comb begin
    tog_d = ~tog_q;
    if (clr) tog_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_d;
  end

  a_r4_advance_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clr) |=> (tog_q != $past(tog_q)));
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !clr) |=> $stable(tog_q));
  a_r9_toggle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tog_q);
endmodule

// File: rtl/fsp_answer.sv
module fsp_answer #(
  parameter int NUM_BLOCKS = 8,
  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_stb,
  input  logic [IDX_W-1:0]      rd_blk,
  input  logic [NUM_BLOCKS-1:0] erase_sel,
  input  logic [NUM_BLOCKS-1:0] erase_fail,
  input  logic                  ph_collect,
  input  logic                  ph_erase,
  input  logic                  ph_suspend,
  input  logic                  err_q,
  input  logic                  abort_q,
  output logic                  stat_sel,
  output logic                  advance
);
  logic blk_ok, blk_erasing, blk_failed;

  assign blk_ok      = (int'(rd_blk) < NUM_BLOCKS);
  assign blk_erasing = blk_ok && erase_sel[rd_blk];
  assign blk_failed  = blk_ok && erase_fail[rd_blk];

  always_comb begin
    stat_sel = abort_q;
    advance  = 1'b0;
    if (err_q) begin
      stat_sel = 1'b1;
      advance  = rd_stb && blk_failed;
    end else if (ph_collect || ph_erase) begin
      stat_sel = 1'b1;
      advance  = rd_stb && blk_erasing && ph_erase;
    end else if (ph_suspend) begin
      stat_sel = stat_sel || blk_erasing;
      advance  = rd_stb && blk_erasing;
    end
  end

  a_r7_abort_selects: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> stat_sel);
  a_r6_error_selects: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> stat_sel);
  a_r8_read_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort_q && !err_q && !ph_collect && !ph_erase && !ph_suspend) |-> !stat_sel);
  a_r4_no_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> !advance);
endmodule

// File: rtl/flash_status_poll.sv
module flash_status_poll #(
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 8,
  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_stb,
  input  logic [IDX_W-1:0]      rd_blk,
  input  logic [NUM_BLOCKS-1:0] erase_sel,
  input  logic [NUM_BLOCKS-1:0] erase_fail,
  input  logic                  ph_collect,
  input  logic                  ph_erase,
  input  logic                  ph_suspend,
  input  logic                  ph_done,
  input  logic                  prog_stb,
  input  logic [DATA_W-1:0]     prog_old,
  input  logic [DATA_W-1:0]     prog_new,
  input  logic                  buf_abort,
  input  logic                  cmd_reset,
  input  logic                  cmd_abort_reset,
  output logic [7:0]            stat_byte,
  output logic                  stat_sel
);
  import flash_status_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic       err_q, timer_q, abort_q, tog_q, advance;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  fsp_flags #(.DATA_W(DATA_W)) i_flags (
    .clk(clk), .rst_n(rst_n_s),
    .prog_stb(prog_stb), .prog_old(prog_old), .prog_new(prog_new),
    .buf_abort(buf_abort), .cmd_reset(cmd_reset), .cmd_abort_reset(cmd_abort_reset),
    .ph_collect(ph_collect), .ph_erase(ph_erase), .ph_done(ph_done),
    .err_q(err_q), .timer_q(timer_q), .abort_q(abort_q)
  );

  fsp_answer #(.NUM_BLOCKS(NUM_BLOCKS)) i_answer (
    .clk(clk), .rst_n(rst_n_s),
    .rd_stb(rd_stb), .rd_blk(rd_blk),
    .erase_sel(erase_sel), .erase_fail(erase_fail),
    .ph_collect(ph_collect), .ph_erase(ph_erase), .ph_suspend(ph_suspend),
    .err_q(err_q), .abort_q(abort_q),
    .stat_sel(stat_sel), .advance(advance)
  );

  fsp_toggle i_toggle (
    .clk(clk), .rst_n(rst_n_s),
    .advance(advance), .clr(cmd_reset),
    .tog_q(tog_q)
  );

  always_comb begin
    stat_byte            = '0;
    stat_byte[BIT_ERR]   = err_q;
    stat_byte[BIT_TIMER] = timer_q;
    stat_byte[BIT_TOG]   = tog_q;
    stat_byte[BIT_ABORT] = abort_q;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n_s |-> (stat_byte == 8'h00));
endmodule

// File: tb/test_flash_status_poll.sv
module test_flash_status_poll;
  localparam int NB = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_stb;
  logic [2:0]    rd_blk;
  logic [NB-1:0] erase_sel, erase_fail;
  logic          ph_collect, ph_erase, ph_suspend, ph_done;
  logic          prog_stb;
  logic [DW-1:0] prog_old, prog_new;
  logic          buf_abort, cmd_reset, cmd_abort_reset;
  logic [7:0]    stat_byte;
  logic          stat_sel;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_status_poll #(.NUM_BLOCKS(NB), .DATA_W(DW)) i_flash_status_poll (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_blk(rd_blk),
    .erase_sel(erase_sel), .erase_fail(erase_fail),
    .ph_collect(ph_collect), .ph_erase(ph_erase), .ph_suspend(ph_suspend), .ph_done(ph_done),
    .prog_stb(prog_stb), .prog_old(prog_old), .prog_new(prog_new),
    .buf_abort(buf_abort), .cmd_reset(cmd_reset), .cmd_abort_reset(cmd_abort_reset),
    .stat_byte(stat_byte), .stat_sel(stat_sel)
  );

  // vector: {rd, blk[2:0], phase{collect,erase,suspend,done}, exp_stat[7:0], exp_sel}
  // erase_sel = 8'h06 (blocks 1,2), erase_fail = 8'h04 for the whole table
  localparam logic [16:0] VEC [12] = '{
    {1'b1, 3'd1, 4'b1000, 8'h00, 1'b1},  // R3 collect: timer 0, no toggle
    {1'b0, 3'd0, 4'b0100, 8'h00, 1'b1},  // R3 erase seen, timer set after edge
    {1'b1, 3'd1, 4'b0100, 8'h08, 1'b1},  // R4 selected read, toggles
    {1'b1, 3'd2, 4'b0100, 8'h0C, 1'b1},  // R4 selected read, toggles back
    {1'b1, 3'd5, 4'b0100, 8'h08, 1'b1},  // R4 unselected block: no toggle
    {1'b0, 3'd0, 4'b0100, 8'h08, 1'b1},  // R4 idle cycle: no toggle
    {1'b1, 3'd2, 4'b0100, 8'h08, 1'b1},  // R4 toggles
    {1'b1, 3'd1, 4'b0010, 8'h0C, 1'b1},  // R5 suspend selected: toggles, timer kept
    {1'b1, 3'd4, 4'b0010, 8'h08, 1'b0},  // R5 suspend unselected: array data
    {1'b1, 3'd2, 4'b0010, 8'h08, 1'b1},  // R5 toggles
    {1'b1, 3'd3, 4'b0001, 8'h0C, 1'b0},  // R8 done: read mode, timer cleared next
    {1'b1, 3'd3, 4'b0000, 8'h04, 1'b0}   // R8 idle read mode
  };

  task automatic chk(input string req, input logic [7:0] st_exp, input logic sel_exp);
    checks++;
    if (stat_byte !== st_exp || stat_sel !== sel_exp) begin
      failures++;
      $display("FAIL %s actual stat=%02h sel=%0b expected stat=%02h sel=%0b",
               req, stat_byte, stat_sel, st_exp, sel_exp);
    end
  endtask

  task automatic clear_inputs();
    rd_stb = 1'b0; rd_blk = '0;
    ph_collect = 1'b0; ph_erase = 1'b0; ph_suspend = 1'b0; ph_done = 1'b0;
    prog_stb = 1'b0; prog_old = '0; prog_new = '0;
    buf_abort = 1'b0; cmd_reset = 1'b0; cmd_abort_reset = 1'b0;
  endtask

  // settle at negedge with strobes cleared, then check
  task automatic idle_chk(input string req, input logic [7:0] st_exp, input logic sel_exp);
    @(negedge clk);
    clear_inputs();
    #1;
    chk(req, st_exp, sel_exp);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] blk, input logic [7:0] st_exp,
                        input logic sel_exp);
    @(negedge clk);
    clear_inputs();
    rd_stb = 1'b1; rd_blk = blk;
    #1;
    chk(req, st_exp, sel_exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    clear_inputs();
    erase_sel = 8'h06; erase_fail = 8'h04;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in reset", 8'h00, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    idle_chk("R1 after reset", 8'h00, 1'b0);
    rd_chk("R10 first toggle read state", 3'd1, 8'h00, 1'b0);

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      clear_inputs();
      rd_stb = VEC[i][16]; rd_blk = VEC[i][15:13];
      {ph_collect, ph_erase, ph_suspend, ph_done} = VEC[i][12:9];
      #1;
      chk($sformatf("R4/R5 table step %0d", i), VEC[i][8:1], VEC[i][0]);
    end

    // R2: clearing-only program does not set the error flag
    @(negedge clk); clear_inputs();
    prog_stb = 1'b1; prog_old = 8'hF0; prog_new = 8'h30;
    idle_chk("R2 clear-only program", 8'h04, 1'b0);
    // R2: raising a bit sets the error flag; R6 error forces status
    @(negedge clk); clear_inputs();
    prog_stb = 1'b1; prog_old = 8'h0F; prog_new = 8'h1F;
    idle_chk("R2 raise sets error", 8'h24, 1'b1);
    // R6: toggle only on failed blocks
    rd_chk("R6 failed block read", 3'd2, 8'h24, 1'b1);
    rd_chk("R6 healthy block holds", 3'd1, 8'h20, 1'b1);
    rd_chk("R6 failed block again", 3'd2, 8'h20, 1'b1);
    idle_chk("R6 toggled back", 8'h24, 1'b1);
    // R9: general reset wins over a same-cycle error set
    @(negedge clk); clear_inputs();
    cmd_reset = 1'b1; prog_stb = 1'b1; prog_old = 8'h00; prog_new = 8'h01;
    idle_chk("R9 reset clears flags", 8'h00, 1'b0);
    // R7: abort flag
    @(negedge clk); clear_inputs(); buf_abort = 1'b1;
    idle_chk("R7 abort sets", 8'h02, 1'b1);
    @(negedge clk); clear_inputs(); cmd_reset = 1'b1;
    idle_chk("R7 survives general reset", 8'h02, 1'b1);
    @(negedge clk); clear_inputs(); cmd_abort_reset = 1'b1;
    idle_chk("R7 abort-reset clears", 8'h00, 1'b0);
    @(negedge clk); clear_inputs(); cmd_abort_reset = 1'b1; buf_abort = 1'b1;
    idle_chk("R7 abort-reset wins", 8'h00, 1'b0);
    // R3: reopened collection window clears the timer
    @(negedge clk); clear_inputs(); ph_erase = 1'b1;
    #1; chk("R3 erase starts", 8'h00, 1'b1);
    @(negedge clk); clear_inputs(); ph_collect = 1'b1;
    #1; chk("R3 timer set", 8'h08, 1'b1);
    idle_chk("R3 timer cleared by collect", 8'h00, 1'b0);
    // R1: asynchronous reset from a busy state
    @(negedge clk); clear_inputs(); prog_stb = 1'b1; prog_new = 8'h01;
    idle_chk("R2 error before reset", 8'h20, 1'b1);
    #2; rst_n = 1'b0; #1;
    chk("R1 async reset", 8'h00, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule